// File: doc/BRIEF.md
# Frame-Pulse Phase Comparator for a Video-Locked Clock Loop

This block is the digital half of a clock loop that locks a fast local clock (nominally 81 MHz) to the video frame rate. It counts the fast clock down to a local frame pulse. It counts a separate 27 MHz reference clock down to a reference frame pulse, which is carried across into the fast domain. On each reference pulse it measures how far that pulse sits from the nearest local frame pulse, in fast-clock cycles. It turns the latched error into a pulse-width-modulated output. An external loop filter smooths that output into the control voltage of the oscillator.

Two inputs set how the block works. One chooses the 29.97 Hz or the 25 Hz frame standard, and each standard has its own divide ratio in both clock domains. The other chooses the reference: either the pulse divided from 27 MHz, or a frame pulse decoded from an incoming stream and delivered on a fast-domain input. When the reference goes missing, the block drops its lock flag and holds the modulator at half duty. When either mode input changes, the local divider realigns to the next reference pulse, and the error of that pulse is thrown away. The block also puts out the fast clock divided by two, with exactly 50 % duty.

Top module: `fpll_phase_cmp`

## Requirements
- R1: `local_frame` is a one-cycle pulse that repeats every `LOC_DIV_NTSC` fast cycles when `pal_mode`=0 and every `LOC_DIV_PAL` fast cycles when `pal_mode`=1.
- R2: With `ext_mode`=0, the reference is `clk_ref` divided by `REF_DIV_NTSC` or `REF_DIV_PAL`, according to `pal_mode`. It appears on `ref_frame` as a one-cycle fast-domain pulse, so successive `ref_frame` pulses are spaced by the matching local period.
- R3: With `ext_mode`=1, `ref_frame` follows `ext_frame`. With `ext_mode`=0, `ext_frame` has no effect on `ref_frame`, `phase_err` or `locked`.
- R4: On each counted reference pulse, `phase_err` latches a two's-complement count of fast cycles measured from the nearest local frame pulse to the reference pulse. The value is positive when the reference comes later, and it lies within half a frame. `locked` is then set.
- R5: While `locked`=1, `pwm_out` is high for D of every 2^PWM_BITS cycles. D = clamp(2^(PWM_BITS-1) + (phase_err >>> ERR_SHIFT), 0, 2^PWM_BITS), so zero error gives 50 % duty.
- R6: A new duty takes effect only at a carrier boundary. Rising edges of `pwm_out` therefore always fall on the same phase of the free-running carrier counter.
- R7: If no reference pulse arrives for 1.5 local frame periods, `locked` falls and `pwm_out` returns to 50 % duty. `phase_err` keeps its last value.
- R8: A change of `ext_mode` or `pal_mode` clears `locked`. The next reference pulse restarts the local divider, so the next `local_frame` comes exactly one local period later. That pulse leaves `phase_err` unchanged and `locked` low.
- R9: `clk_half` toggles on every fast clock edge, which gives half the fast rate at 50 % duty.
- R10: While `rst_n` is low, `locked`=0, `phase_err`=0 and `clk_half`=0. After reset the duty is 50 %, and the first reference pulse is treated as an alignment pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast | input | 1 | Fast local clock (nominally 81 MHz) |
| rst_n | input | 1 | Active-low asynchronous reset, both domains |
| clk_ref | input | 1 | 27 MHz reference clock |
| ext_mode | input | 1 | 1 selects `ext_frame` as the reference |
| pal_mode | input | 1 | 1 selects the 25 Hz standard, 0 the 29.97 Hz standard |
| ext_frame | input | 1 | Decoded stream frame pulse, fast domain, one cycle |
| clk_half | output | 1 | Fast clock divided by two |
| local_frame | output | 1 | Local frame pulse |
| ref_frame | output | 1 | Selected reference pulse in the fast domain |
| pwm_out | output | 1 | Phase-error modulator output |
| locked | output | 1 | Reference present and error valid |
| phase_err | output | ERR_W | Last latched signed phase error |

## Verification
The hardest case to reach is the carrier-boundary rule. Its effect shows only as the phase of `pwm_out` edges, and the carrier counter is not visible at the ports. The bench first records a rising edge while the duty is intermediate. It then drives the error to the negative clamp (output held low) and straight to the positive clamp. The first rising edge after that change must fall a whole number of carrier periods after the recorded one. Exact error values come from timing `ext_frame` pulses against the observed `local_frame`. A standard switch, followed by a misplaced alignment pulse and a pulse 365 cycles later, shows both that the error is discarded and that the PAL ratio is in use.

// File: rtl/fpll_phase_cmp.sv
module fpll_phase_cmp #(
  parameter int LOC_DIV_NTSC = 2702700,
  parameter int LOC_DIV_PAL  = 3240000,
  parameter int REF_DIV_NTSC = 900900,
  parameter int REF_DIV_PAL  = 1080000,
  parameter int PWM_BITS     = 8,
  parameter int ERR_SHIFT    = 12,
  parameter int ERR_W        = $clog2(((LOC_DIV_PAL > LOC_DIV_NTSC) ? LOC_DIV_PAL : LOC_DIV_NTSC) + 1) + 1
) (
  input  logic                    clk_fast,
  input  logic                    rst_n,
  input  logic                    clk_ref,
  input  logic                    ext_mode,
  input  logic                    pal_mode,
  input  logic                    ext_frame,
  output logic                    clk_half,
  output logic                    local_frame,
  output logic                    ref_frame,
  output logic                    pwm_out,
  output logic                    locked,
  output logic signed [ERR_W-1:0] phase_err
);

  localparam int REF_MAX = (REF_DIV_PAL > REF_DIV_NTSC) ? REF_DIV_PAL : REF_DIV_NTSC;
  localparam int LW   = ERR_W - 1;
  localparam int RW   = $clog2(REF_MAX + 1);
  localparam int TW   = LW + 1;
  localparam int SW   = ERR_W + PWM_BITS + 1;
  localparam int HALF = 2 ** (PWM_BITS - 1);
  localparam int FULL = 2 ** PWM_BITS;

  // reference clock domain
  logic [1:0]    pal_ref_s;
  logic [RW-1:0] ref_cnt, ref_lim;
  logic          ref_tgl;

  assign ref_lim = pal_ref_s[1] ? RW'(REF_DIV_PAL - 1) : RW'(REF_DIV_NTSC - 1);

  always_ff @(posedge clk_ref or negedge rst_n) begin
    if (!rst_n) begin
      pal_ref_s <= '0;
      ref_cnt   <= '0;
      ref_tgl   <= 1'b0;
    end else begin
      pal_ref_s <= {pal_ref_s[0], pal_mode};
      if (ref_cnt >= ref_lim) begin
        ref_cnt <= '0;
        ref_tgl <= ~ref_tgl;
      end else begin
        ref_cnt <= ref_cnt + RW'(1);
      end
    end
  end

  // fast clock domain
  logic [2:0]             tgl_s;
  logic                   int_pulse, ref_pulse, mode_chg, align, meas, resync_pend;
  logic [1:0]             mode_q;
  logic [LW-1:0]          loc_cnt, cur_div, loc_lim;
  logic [TW-1:0]          tmo_cnt, tmo_lim;
  logic signed [ERR_W-1:0] err_next;

  assign int_pulse   = tgl_s[2] ^ tgl_s[1];
  assign ref_pulse   = ext_mode ? ext_frame : int_pulse;
  assign ref_frame   = ref_pulse;
  assign mode_chg    = mode_q != {ext_mode, pal_mode};
  assign align       = resync_pend & ref_pulse & ~mode_chg;
  assign meas        = ~resync_pend & ref_pulse & ~mode_chg;
  assign cur_div     = pal_mode ? LW'(LOC_DIV_PAL) : LW'(LOC_DIV_NTSC);
  assign loc_lim     = cur_div - LW'(1);
  assign tmo_lim     = TW'(cur_div) + TW'(cur_div >> 1);
  assign local_frame = (loc_cnt == '0);
  assign err_next    = (loc_cnt < (cur_div >> 1)) ? $signed({1'b0, loc_cnt})
                                                  : $signed({1'b0, loc_cnt}) - $signed({1'b0, cur_div});

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      tgl_s       <= '0;
      mode_q      <= '0;
      loc_cnt     <= '0;
      resync_pend <= 1'b1;
      phase_err   <= '0;
      tmo_cnt     <= '0;
      locked      <= 1'b0;
      clk_half    <= 1'b0;
    end else begin
      tgl_s    <= {tgl_s[1:0], ref_tgl};
      mode_q   <= {ext_mode, pal_mode};
      clk_half <= ~clk_half;
      if (align)                  loc_cnt <= LW'(1);
      else if (loc_cnt >= loc_lim) loc_cnt <= '0;
      else                        loc_cnt <= loc_cnt + LW'(1);
      if (mode_chg)   resync_pend <= 1'b1;
      else if (align) resync_pend <= 1'b0;
      if (meas) phase_err <= err_next;
      if (ref_pulse || mode_chg)  tmo_cnt <= '0;
      else if (tmo_cnt < tmo_lim) tmo_cnt <= tmo_cnt + TW'(1);
      if (mode_chg)                 locked <= 1'b0;
      else if (meas)                locked <= 1'b1;
      else if (tmo_cnt >= tmo_lim)  locked <= 1'b0;
    end
  end

  // modulator
  logic [PWM_BITS-1:0]  pcnt;
  logic [PWM_BITS:0]    duty_act, duty_tgt;
  logic signed [SW-1:0] sum;

  assign sum = SW'(phase_err >>> ERR_SHIFT) + SW'(HALF);

  always_comb begin
    if (!locked)                duty_tgt = (PWM_BITS + 1)'(HALF);
    else if (sum[SW-1])         duty_tgt = '0;
    else if (sum > SW'(FULL))   duty_tgt = (PWM_BITS + 1)'(FULL);
    else                        duty_tgt = sum[PWM_BITS:0];
  end

  always_ff @(posedge clk_fast or negedge rst_n) begin
    if (!rst_n) begin
      pcnt     <= '0;
      duty_act <= (PWM_BITS + 1)'(HALF);
    end else begin
      pcnt <= pcnt + PWM_BITS'(1);
      if (pcnt == '1) duty_act <= duty_tgt;
    end
  end

  assign pwm_out = {1'b0, pcnt} < duty_act;

  assert_frame_single_R1: assert property (@(posedge clk_fast) disable iff (!rst_n)
    local_frame |=> !local_frame);
  assert_discard_R8: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (resync_pend && ref_pulse) |=> ($stable(phase_err) && !locked));
  assert_duty_boundary_R6: assert property (@(posedge clk_fast) disable iff (!rst_n)
    !$stable(duty_act) |-> ($past(pcnt) == '1));
  assert_duty_range_R5: assert property (@(posedge clk_fast) disable iff (!rst_n)
    duty_act <= (PWM_BITS + 1)'(FULL));
  assert_timeout_unlock_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (tmo_cnt >= tmo_lim && !ref_pulse) |=> !locked);
  assert_unlocked_half_R7: assert property (@(posedge clk_fast) disable iff (!rst_n)
    (!locked && pcnt == '1) |=> (duty_act == (PWM_BITS + 1)'(HALF)));
  assert_half_toggle_R9: assert property (@(posedge clk_fast) disable iff (!rst_n)
    $past(rst_n) |-> (clk_half != $past(clk_half)));

endmodule

// File: tb/fpll_phase_cmp_tb.sv
module fpll_phase_cmp_tb;
  localparam int LN = 300, LP = 360, RN = 100, RP = 120, PB = 6, EW = 10;

  logic clk_fast = 0, clk_ref = 0, rst_n = 0;
  logic ext_mode = 1, pal_mode = 0, ext_frame = 0;
  logic clk_half, local_frame, ref_frame, pwm_out, locked;
  logic signed [EW-1:0] phase_err;
  int checks = 0, failures = 0, cyc = 0;
  bit done = 0;

  fpll_phase_cmp #(.LOC_DIV_NTSC(LN), .LOC_DIV_PAL(LP), .REF_DIV_NTSC(RN), .REF_DIV_PAL(RP),
                   .PWM_BITS(PB), .ERR_SHIFT(0), .ERR_W(EW)) u_dut (
    .clk_fast(clk_fast), .rst_n(rst_n), .clk_ref(clk_ref), .ext_mode(ext_mode),
    .pal_mode(pal_mode), .ext_frame(ext_frame), .clk_half(clk_half),
    .local_frame(local_frame), .ref_frame(ref_frame), .pwm_out(pwm_out),
    .locked(locked), .phase_err(phase_err));

  always #5 clk_fast = ~clk_fast;
  initial begin #2; forever #15 clk_ref = ~clk_ref; end
  always @(posedge clk_fast) cyc++;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  task automatic wait_local();
    do @(negedge clk_fast); while (!local_frame);
  endtask

  task automatic pulse_ext();
    ext_frame = 1;
    @(negedge clk_fast);
    ext_frame = 0;
  endtask

  task automatic duty(output int hi);
    repeat (130) @(negedge clk_fast);
    hi = 0;
    repeat (64) begin @(negedge clk_fast); if (pwm_out) hi++; end
  endtask

  task automatic gap(input bit use_ref, output int n);
    do @(negedge clk_fast); while (!(use_ref ? ref_frame : local_frame));
    n = 0;
    do begin @(negedge clk_fast); n++; end while (!(use_ref ? ref_frame : local_frame));
  endtask

  task automatic meas_err(input int k, input int div);
    wait_local();
    repeat (k >= 0 ? k : div + k) @(negedge clk_fast);
    pulse_ext();
    chk("R4 phase error", int'(phase_err), k);
    chk("R4 lock set", int'(locked), 1);
  endtask

  task automatic t_reset();
    int hi;
    repeat (10) @(negedge clk_fast);
    chk("R10 reset locked", int'(locked), 0);
    chk("R10 reset phase_err", int'(phase_err), 0);
    chk("R10 reset clk_half", int'(clk_half), 0);
    rst_n = 1;
    duty(hi);
    chk("R10 duty after reset", hi, 32);
  endtask

  task automatic t_align();
    int n;
    repeat (50) @(negedge clk_fast);
    pulse_ext();
    n = 1;
    while (!local_frame) begin @(negedge clk_fast); n++; end
    chk("R8 realign to first pulse", n, LN);
    chk("R8 align pulse keeps unlocked", int'(locked), 0);
    chk("R8 align pulse discarded", int'(phase_err), 0);
    gap(0, n);
    chk("R1 local period ntsc", n, LN);
  endtask

  task automatic t_errors();
    int hi, t_a, t_b;
    meas_err(0, LN);
    duty(hi);
    chk("R5 zero error half duty", hi, 32);
    meas_err(5, LN);
    duty(hi);
    chk("R5 duty +5", hi, 37);
    do @(negedge clk_fast); while (pwm_out);
    do @(negedge clk_fast); while (!pwm_out);
    t_a = cyc;
    meas_err(-3, LN);
    duty(hi);
    chk("R5 duty -3", hi, 29);
    meas_err(-40, LN);
    duty(hi);
    chk("R5 clamp low", hi, 0);
    meas_err(40, LN);
    do @(negedge clk_fast); while (!pwm_out);
    t_b = cyc;
    chk("R6 duty change on carrier boundary", (t_b - t_a) % 64, 0);
    duty(hi);
    chk("R5 clamp high", hi, 64);
  endtask

  task automatic t_timeout();
    int hi;
    meas_err(0, LN);
    repeat (398) @(negedge clk_fast);
    chk("R7 still locked before timeout", int'(locked), 1);
    repeat (100) @(negedge clk_fast);
    chk("R7 unlocked after timeout", int'(locked), 0);
    duty(hi);
    chk("R7 half duty when unlocked", hi, 32);
    chk("R7 error retained", int'(phase_err), 0);
  endtask

  task automatic t_pal();
    int n;
    meas_err(7, LN);
    pal_mode = 1;
    @(negedge clk_fast);
    chk("R8 standard change clears lock", int'(locked), 0);
    repeat (77) @(negedge clk_fast);
    pulse_ext();
    chk("R8 next error discarded", int'(phase_err), 7);
    chk("R8 still unlocked after align", int'(locked), 0);
    repeat (364) @(negedge clk_fast);
    pulse_ext();
    chk("R8 R1 pal error after realign", int'(phase_err), 5);
    chk("R8 relocked", int'(locked), 1);
    gap(0, n);
    chk("R1 local period pal", n, LP);
  endtask

  task automatic t_internal();
    int n;
    ext_mode = 0;
    gap(1, n);
    chk("R2 ref period pal", n, LP);
    @(negedge clk_fast);
    chk("R2 internal ref error", int'(phase_err), 0);
    chk("R2 internal ref locked", int'(locked), 1);
    repeat (100) @(negedge clk_fast);
    ext_frame = 1;
    #1;
    chk("R3 ext_frame ignored on ref_frame", int'(ref_frame), 0);
    @(negedge clk_fast);
    ext_frame = 0;
    chk("R3 ext_frame ignored on error", int'(phase_err), 0);
    chk("R3 ext_frame ignored on lock", int'(locked), 1);
    do @(negedge clk_fast); while (!ref_frame);
    @(negedge clk_fast);
    chk("R3 internal error unchanged", int'(phase_err), 0);
    pal_mode = 0;
    gap(1, n);
    gap(1, n);
    chk("R2 ref period ntsc", n, LN);
  endtask

  task automatic t_half();
    logic prev;
    @(negedge clk_fast);
    prev = clk_half;
    repeat (12) begin
      @(negedge clk_fast);
      chk("R9 half clock toggles", int'(clk_half), int'(!prev));
      prev = clk_half;
    end
  endtask

  initial begin
    t_reset();
    t_align();
    t_errors();
    t_timeout();
    t_pal();
    t_internal();
    t_half();
    done = 1;
    report();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_fast);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      report();
      $finish;
    end
  end
endmodule